// File: doc/BRIEF.md
# Quadrant-zero opcode decoder

This block is a purely combinational decoder for the 8-bit opcodes whose two top bits are `00`. It reports the instruction class and the register selectors taken from the opcode's bit fields. It also gives the number of operand bytes that follow the opcode. A fetch or issue stage drives the opcode byte and reads the results in the same cycle. It uses the operand count to know how many further bytes to collect. A two-byte operand is an address or immediate, sent low byte first. The decoder does not fetch or execute anything. It does not handle prefixed pages or the other three quadrants.

Three separate fields are extracted from the opcode:
- an 8-bit register selector from bits 5..3;
- a register-pair selector from bits 4..5 (bits 5..4);
- a branch condition from bits 4..3.

Only the selector that the instruction class uses is driven. The others read zero. Some opcodes are outside the quadrant, or are forms that are not valid in this quadrant. For these, the block lowers `known_o` and drives every other output to its idle value. Decimal adjust and the carry-flag set/complement opcodes are accepted as known. They are reported under one shared class that this block does not decode further.

Top module: `qz_decoder`

## Requirements
- R1: An opcode with bits 7..6 not equal to `00`, or equal to 0x32 or 0x3A, gives `known_o`=0, `class_o`=31, `oplen_o`=0, and all selectors, use flags and `mem_o` at 0. Every other opcode gives `known_o`=1.
- R2: Class codes for the relative-branch and control forms:
  - 0x00 no-op gives class 0.
  - 0x08 accumulator/flags exchange with the alternate copy gives class 1.
  - 0x10 decrement-B-and-branch gives class 2.
  - 0x18 unconditional relative branch gives class 3.
  - 0x20, 0x28, 0x30 and 0x38 give conditional relative branch, class 4.
- R3: Class codes for the register-pair and 8-bit register forms:
  - `00pp0001` gives 16-bit immediate load, class 5.
  - `00pp1001` gives add pair to HL, class 6.
  - `00pp0011` gives increment pair, class 11.
  - `00pp1011` gives decrement pair, class 12.
  - `00rrr100` gives increment register, class 13.
  - `00rrr101` gives decrement register, class 14.
  - `00rrr110` gives load register from an immediate byte, class 15.
- R4: Class codes for the memory forms:
  - 0x02 and 0x12 give store A through pair, class 7.
  - 0x0A and 0x1A give load A through pair, class 8.
  - 0x22 gives store HL to a direct address, class 9.
  - 0x2A gives load HL from a direct address, class 10.
- R5: Class codes for the accumulator-only forms:
  - 0x07 gives class 16, 0x0F gives class 17, 0x17 gives class 18 and 0x1F gives class 19. These are the rotates: left circular, right circular, left through carry and right through carry.
  - 0x2F (complement A) gives class 20.
  - 0x27, 0x37 and 0x3F give the undecoded-but-valid class 21.
- R6: For classes 5, 6, 7, 8, 11 and 12, `use_pair_o`=1 and `pair_o` carries bits 5..4, with 00=BC, 01=DE, 10=HL, 11=SP. For all other classes, `use_pair_o`=0 and `pair_o`=0.
- R7: For classes 13, 14 and 15, `use_reg8_o`=1 and `reg8_o` carries bits 5..3, with 000=B, 001=C, 010=D, 011=E, 100=H, 101=L, 110=memory at HL, 111=A. `mem_o`=1 exactly when that field is 110. For all other classes, `use_reg8_o`, `reg8_o` and `mem_o` are 0.
- R8: For class 4 only, `use_cond_o`=1 and `cond_o` carries bits 4..3, with 00=not zero, 01=zero, 10=no carry, 11=carry. For all other classes, `use_cond_o`=0 and `cond_o`=0.
- R9: `oplen_o` is 2 for classes 5, 9 and 10, where the operand is sent low byte first. It is 1 for classes 2, 3, 4 and 15. It is 0 otherwise. At most one use flag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Opcode byte |
| known_o | output | 1 | Opcode belongs to a decoded or accepted form |
| class_o | output | 5 | Instruction class code |
| reg8_o | output | 3 | 8-bit register selector |
| use_reg8_o | output | 1 | reg8_o is meaningful |
| mem_o | output | 1 | Register selector names the memory at HL |
| pair_o | output | 2 | Register-pair selector |
| use_pair_o | output | 1 | pair_o is meaningful |
| cond_o | output | 2 | Branch condition selector |
| use_cond_o | output | 1 | cond_o is meaningful |
| oplen_o | output | 2 | Operand bytes following the opcode |

## Verification
The bench first sweeps all 64 quadrant-zero opcodes in order. Each pair, register and condition value is therefore paired with every low-bit pattern. This separates the field extraction from the class choice. Directed cases cover:
- the two holes 0x32 and 0x3A, which isolate the pair-3 exception of the memory forms;
- 0x27/0x37/0x3F, which show the accepted-but-undecoded class;
- a register field of 110, which isolates the memory flag.

Random opcodes over the full byte range then mix in the other quadrants. These must all read as unknown with quiet outputs.

// File: rtl/qz_pkg.sv
package qz_pkg;
  localparam int OP_W   = 8;
  localparam int CLS_W  = 5;
  localparam int R8_W   = 3;
  localparam int PR_W   = 2;
  localparam int CC_W   = 2;
  localparam int LEN_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP     = 5'd0,
    CLS_EXAF    = 5'd1,
    CLS_DJNZ    = 5'd2,
    CLS_JR      = 5'd3,
    CLS_JRCC    = 5'd4,
    CLS_LD16I   = 5'd5,
    CLS_ADD16   = 5'd6,
    CLS_STA_IND = 5'd7,
    CLS_LDA_IND = 5'd8,
    CLS_ST16_DIR= 5'd9,
    CLS_LD16_DIR= 5'd10,
    CLS_INC16   = 5'd11,
    CLS_DEC16   = 5'd12,
    CLS_INC8    = 5'd13,
    CLS_DEC8    = 5'd14,
    CLS_LD8I    = 5'd15,
    CLS_ROL     = 5'd16,
    CLS_ROR     = 5'd17,
    CLS_RLC     = 5'd18,
    CLS_RRC     = 5'd19,
    CLS_CPL     = 5'd20,
    CLS_MISC    = 5'd21,
    CLS_NONE    = 5'd31
  } qz_cls_e;

  localparam logic [R8_W-1:0] R8_MEM = 3'b110;
endpackage

// File: rtl/qz_fields.sv
module qz_fields
  import qz_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            quad_o,
  output logic [2:0]      y_o,
  output logic [2:0]      z_o,
  output logic [1:0]      p_o,
  output logic            q_o
);
  assign quad_o = (op_i[7:6] == 2'b00);
  assign y_o    = op_i[5:3];
  assign z_o    = op_i[2:0];
  assign p_o    = op_i[5:4];
  assign q_o    = op_i[3];

  always_comb begin
    if (!$isunknown(op_i))
      AST_FIELD_ALIAS: assert (p_o == y_o[2:1] && q_o == y_o[0]) else $error("field split"); // R6
  end
endmodule

// File: rtl/qz_class.sv
module qz_class
  import qz_pkg::*;
(
  input  logic       quad_i,
  input  logic [2:0] y_i,
  input  logic [2:0] z_i,
  input  logic [1:0] p_i,
  input  logic       q_i,
  output qz_cls_e    cls_o,
  output logic       known_o
);
  always_comb begin
    cls_o = CLS_NONE;
    if (quad_i) begin
      case (z_i)
        3'd0: begin
          case (y_i)
            3'd0:    cls_o = CLS_NOP;
            3'd1:    cls_o = CLS_EXAF;
            3'd2:    cls_o = CLS_DJNZ;
            3'd3:    cls_o = CLS_JR;
            default: cls_o = CLS_JRCC;
          endcase
        end
        3'd1: cls_o = q_i ? CLS_ADD16 : CLS_LD16I;
        3'd2: begin
          // pair 11 has no indirect form in this decoder
          if (!p_i[1])      cls_o = q_i ? CLS_LDA_IND  : CLS_STA_IND;
          else if (!p_i[0]) cls_o = q_i ? CLS_LD16_DIR : CLS_ST16_DIR;
          else              cls_o = CLS_NONE;
        end
        3'd3: cls_o = q_i ? CLS_DEC16 : CLS_INC16;
        3'd4: cls_o = CLS_INC8;
        3'd5: cls_o = CLS_DEC8;
        3'd6: cls_o = CLS_LD8I;
        default: begin
          case (y_i)
            3'd0:    cls_o = CLS_ROL;
            3'd1:    cls_o = CLS_ROR;
            3'd2:    cls_o = CLS_RLC;
            3'd3:    cls_o = CLS_RRC;
            3'd5:    cls_o = CLS_CPL;
            default: cls_o = CLS_MISC;
          endcase
        end
      endcase
    end
  end

  assign known_o = (cls_o != CLS_NONE);

  always_comb begin
    if (!$isunknown({quad_i, y_i, z_i}))
      AST_OUTSIDE_UNKNOWN: assert (quad_i || !known_o) else $error("outside quadrant known"); // R1
  end
endmodule

// File: rtl/qz_sel.sv
module qz_sel
  import qz_pkg::*;
(
  input  qz_cls_e         cls_i,
  input  logic [2:0]      y_i,
  input  logic [1:0]      p_i,
  output logic [R8_W-1:0] reg8_o,
  output logic            use_reg8_o,
  output logic            mem_o,
  output logic [PR_W-1:0] pair_o,
  output logic            use_pair_o,
  output logic [CC_W-1:0] cond_o,
  output logic            use_cond_o
);
  always_comb begin
    case (cls_i)
      CLS_LD16I, CLS_ADD16, CLS_STA_IND, CLS_LDA_IND,
      CLS_INC16, CLS_DEC16: use_pair_o = 1'b1;
      default:              use_pair_o = 1'b0;
    endcase
    case (cls_i)
      CLS_INC8, CLS_DEC8, CLS_LD8I: use_reg8_o = 1'b1;
      default:                      use_reg8_o = 1'b0;
    endcase
    use_cond_o = (cls_i == CLS_JRCC);
  end

  assign pair_o = use_pair_o ? p_i      : '0;
  assign reg8_o = use_reg8_o ? y_i      : '0;
  assign cond_o = use_cond_o ? y_i[1:0] : '0;
  assign mem_o  = use_reg8_o && (y_i == R8_MEM);

  always_comb begin
    if (!$isunknown({cls_i, y_i, p_i})) begin
      AST_ONE_SEL: assert ($onehot0({use_reg8_o, use_pair_o, use_cond_o})) else $error("two selectors"); // R9
      AST_MEM_REG: assert (!mem_o || (use_reg8_o && reg8_o == R8_MEM)) else $error("mem flag"); // R7
      AST_IDLE_PAIR: assert (use_pair_o || pair_o == '0) else $error("pair not idle"); // R6
      AST_IDLE_COND: assert (use_cond_o || cond_o == '0) else $error("cond not idle"); // R8
    end
  end
endmodule

// File: rtl/qz_len.sv
module qz_len
  import qz_pkg::*;
(
  input  qz_cls_e          cls_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    case (cls_i)
      CLS_LD16I, CLS_ST16_DIR, CLS_LD16_DIR:      len_o = 2'd2;
      CLS_DJNZ, CLS_JR, CLS_JRCC, CLS_LD8I:       len_o = 2'd1;
      default:                                    len_o = 2'd0;
    endcase
  end

  always_comb begin
    if (!$isunknown(cls_i))
      AST_NONE_NO_OPND: assert (cls_i != CLS_NONE || len_o == '0) else $error("operands on unknown"); // R1
  end
endmodule

// File: rtl/qz_decoder.sv
module qz_decoder
  import qz_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       known_o,
  output logic [4:0] class_o,
  output logic [2:0] reg8_o,
  output logic       use_reg8_o,
  output logic       mem_o,
  output logic [1:0] pair_o,
  output logic       use_pair_o,
  output logic [1:0] cond_o,
  output logic       use_cond_o,
  output logic [1:0] oplen_o
);
  logic       quad;
  logic [2:0] y, z;
  logic [1:0] p;
  logic       q;
  qz_cls_e    cls;

  qz_fields i_fields (
    .op_i(op_i), .quad_o(quad), .y_o(y), .z_o(z), .p_o(p), .q_o(q)
  );

  qz_class i_class (
    .quad_i(quad), .y_i(y), .z_i(z), .p_i(p), .q_i(q),
    .cls_o(cls), .known_o(known_o)
  );

  qz_sel i_sel (
    .cls_i(cls), .y_i(y), .p_i(p),
    .reg8_o(reg8_o), .use_reg8_o(use_reg8_o), .mem_o(mem_o),
    .pair_o(pair_o), .use_pair_o(use_pair_o),
    .cond_o(cond_o), .use_cond_o(use_cond_o)
  );

  qz_len i_len (.cls_i(cls), .len_o(oplen_o));

  assign class_o = cls;

  always_comb begin
    if (!$isunknown(op_i)) begin
      AST_TWO_BYTE_CLS: assert (oplen_o != 2'd2 || class_o inside {5'd5, 5'd9, 5'd10}) else $error("len 2"); // R9
      AST_HOLES: assert (!(op_i == 8'h32 || op_i == 8'h3A) || !known_o) else $error("hole known"); // R1
      AST_NOP: assert (op_i != 8'h00 || (class_o == 5'd0 && oplen_o == 2'd0)) else $error("nop"); // R2
    end
  end
endmodule

// File: tb/test_qz_decoder.sv
module test_qz_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] op;
  logic       known, use_r8, mem, use_pr, use_cc;
  logic [4:0] cls;
  logic [2:0] r8;
  logic [1:0] pr, cc, len;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qz_decoder i_qz_decoder (
    .op_i(op), .known_o(known), .class_o(cls),
    .reg8_o(r8), .use_reg8_o(use_r8), .mem_o(mem),
    .pair_o(pr), .use_pair_o(use_pr),
    .cond_o(cc), .use_cond_o(use_cc), .oplen_o(len)
  );

  function automatic logic [4:0] ref_cls(input logic [7:0] o);
    casez (o)
      8'h00: return 5'd0;
      8'h08: return 5'd1;
      8'h10: return 5'd2;
      8'h18: return 5'd3;
      8'b001??000: return 5'd4;
      8'b00??0001: return 5'd5;
      8'b00??1001: return 5'd6;
      8'b000?0010: return 5'd7;
      8'b000?1010: return 5'd8;
      8'h22: return 5'd9;
      8'h2A: return 5'd10;
      8'b00??0011: return 5'd11;
      8'b00??1011: return 5'd12;
      8'b00???100: return 5'd13;
      8'b00???101: return 5'd14;
      8'b00???110: return 5'd15;
      8'h07: return 5'd16;
      8'h0F: return 5'd17;
      8'h17: return 5'd18;
      8'h1F: return 5'd19;
      8'h2F: return 5'd20;
      8'h27, 8'h37, 8'h3F: return 5'd21;
      default: return 5'd31;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] c);
    if (c == 5'd31) return "R1";
    if (c <= 5'd4) return "R2";
    if (c inside {5'd7, 5'd8, 5'd9, 5'd10}) return "R4";
    if (c >= 5'd16) return "R5";
    return "R3";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%02h actual=%0d expected=%0d", req, what, op, act, exp);
    end
  endtask

  task automatic try_op(input logic [7:0] o);
    logic [4:0] ec;
    bit ep, er, ec4;
    @(posedge clk);
    op = o;
    @(negedge clk);
    ec  = ref_cls(o);
    ep  = ec inside {5'd5, 5'd6, 5'd7, 5'd8, 5'd11, 5'd12};
    er  = ec inside {5'd13, 5'd14, 5'd15};
    ec4 = (ec == 5'd4);
    chk("R1", "known", int'(known), int'(ec != 5'd31));
    chk(req_of(ec), "class", int'(cls), int'(ec));
    chk("R6", "use_pair", int'(use_pr), int'(ep));
    chk("R6", "pair", int'(pr), ep ? int'(o[5:4]) : 0);
    chk("R7", "use_reg8", int'(use_r8), int'(er));
    chk("R7", "reg8", int'(r8), er ? int'(o[5:3]) : 0);
    chk("R7", "mem", int'(mem), int'(er && o[5:3] == 3'b110));
    chk("R8", "use_cond", int'(use_cc), int'(ec4));
    chk("R8", "cond", int'(cc), ec4 ? int'(o[4:3]) : 0);
    chk("R9", "oplen", int'(len),
        (ec inside {5'd5, 5'd9, 5'd10}) ? 2 :
        (ec inside {5'd2, 5'd3, 5'd4, 5'd15}) ? 1 : 0);
    chk("R9", "one_use", int'(use_pr) + int'(use_r8) + int'(use_cc) <= 1 ? 1 : 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4242));
    op = 8'h00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state / NOP (R2)
    try_op(8'h00);
    // full quadrant sweep
    for (int i = 0; i < 64; i++) try_op(8'(i));
    // directed corners: holes (R1), misc class (R5), memory operand (R7), branch conds (R8)
    try_op(8'h32); try_op(8'h3A);
    try_op(8'h27); try_op(8'h37); try_op(8'h3F);
    try_op(8'h34); try_op(8'h36);
    try_op(8'h38); try_op(8'h20);
    try_op(8'h22); try_op(8'h2A); try_op(8'h31);
    try_op(8'h40); try_op(8'hFF); try_op(8'hC0);
    // random over whole byte range
    for (int k = 0; k < 400; k++) begin
      r = 8'($urandom);
      try_op(r);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule